// File: doc/BRIEF.md
# PS/2 Host Keyboard Link Controller

This block is the host end of a two-wire PS/2 keyboard link. Both wires are open-collector: the block never drives a wire high. It only produces two active-low pull enables, one for the clock wire and one for the data wire. External tri-state buffers turn each enable into "drive 0" or "release". The block runs on a fast system clock. It resynchronises both wires and low-pass filters the slow PS/2 clock before it looks for falling edges.

In the receive direction the keyboard generates the clock. The block collects eleven-bit frames and presents each good byte with a one-cycle strobe. A frame with a bad start bit, a bad stop bit or a bad parity bit is dropped and reported with a one-cycle error strobe. In the transmit direction a command byte, such as an LED setting, is offered through a ready/request handshake. The block first inhibits the link by holding the clock wire low, then asserts the start bit and hands the clock back to the keyboard. It shifts out the byte in step with the keyboard's clock, checks for the keyboard's acknowledge, and then reports completion. A watchdog returns the block to idle if the keyboard stops clocking in the middle of a frame.

Top module: `ps2_host_ctrl`

## Requirements
- R1: After reset, both pull enables are 1 (both wires released), `tx_ready` is 1, and `rx_valid`, `rx_err` and `tx_done` are 0.
- R2: A keyboard frame is sampled on eleven falling clock edges. Bit 0 is the start bit (must be 0). Bits 1 to 8 are the data, least significant bit first. Bit 9 is the parity bit. Bit 10 is the stop bit (must be 1). A good frame raises `rx_valid` for exactly one cycle with the byte on `rx_data`, and `rx_err` stays 0.
- R3: Parity is odd: the eight data bits and the parity bit together hold an odd number of ones (0x38 is sent with parity 0). A frame with wrong parity gives a one-cycle `rx_err` and no `rx_valid`.
- R4: A frame whose start bit is 1 or whose stop bit is 0 gives a one-cycle `rx_err` and no `rx_valid`.
- R5: A low pulse on the clock wire shorter than `FILT_LEN` system cycles is not taken as a falling edge.
- R6: An accepted send pulls the clock wire low for at least `INHIBIT_CYC` cycles. It then pulls the data wire low as the start bit while the clock is still held. Only after that does it release the clock.
- R7: After each keyboard falling edge, the data wire presents the next transmit bit. Edges 1 to 8 present the data, least significant bit first. Edge 9 presents the odd parity bit. Edge 10 releases the wire for the stop bit. The keyboard samples these bits on its rising edges.
- R8: On the eleventh keyboard falling edge the data wire is sampled. `tx_done` pulses once, with `tx_ack_ok` = 1 if the wire was low and 0 if it was high, and `tx_ready` returns to 1.
- R9: If `TIMEOUT_CYC` cycles pass with no falling edge while a frame is in progress in either direction, the block returns to idle. Both wires are released, `tx_ready` is 1, and no strobe is produced for the partial frame.
- R10: `tx_req` is taken only while `tx_ready` is 1. `tx_ready` is 0 while a received frame is in progress or a send is active. Receive and transmit never overlap, so the keyboard's clock edges during a send produce no receive strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_in | input | 1 | Level sensed on the PS/2 clock wire |
| kb_data_in | input | 1 | Level sensed on the PS/2 data wire |
| kb_clk_pull_n | output | 1 | Clock wire pull enable, 0 = drive low, 1 = release |
| kb_data_pull_n | output | 1 | Data wire pull enable, 0 = drive low, 1 = release |
| rx_data | output | 8 | Last good received byte |
| rx_valid | output | 1 | One-cycle strobe for a good received byte |
| rx_err | output | 1 | One-cycle strobe for a dropped frame (parity or framing) |
| tx_ready | output | 1 | Block idle; a send request will be accepted |
| tx_req | input | 1 | Send request, taken when `tx_ready` is 1 |
| tx_byte | input | 8 | Byte to send, captured with the request |
| tx_done | output | 1 | One-cycle strobe at the end of a send |
| tx_ack_ok | output | 1 | With `tx_done`: the keyboard acknowledged |

## Verification
A falling edge on the clock pin goes through two synchroniser stages, `FILT_LEN` filter stages, the filtered-level register and the edge register. As a result, `rx_valid`, `rx_err` and `tx_done` appear `FILT_LEN`+5 system edges after the eleventh falling edge at the pin. A new transmit data level appears equally late after each keyboard falling edge, which is well inside the low half of the PS/2 clock. The bench's scoreboard pushes one expected entry per keyboard frame, and its monitor pops entries at strobes. The driver waits `FILT_LEN`+8 cycles after the last edge before it requires the queue to be empty, so a late strobe, a missing strobe or a stray strobe is each reported. Transmit bits are sampled at the keyboard model's rising edges, half a PS/2 period after the edge that launched them. The inhibit length is counted from the cycle the request is taken.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

  localparam int FRAME_BITS = 11;
  localparam int DATA_BITS  = 8;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_INHIBIT,
    TX_START,
    TX_SHIFT
  } tx_state_t;

  function automatic logic odd_parity(input logic [DATA_BITS-1:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/ps2_sync_filter.sv
module ps2_sync_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level
);

  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
    end
  end

  generate
    if (FILT_LEN > 1) begin : g_filter
      logic [FILT_LEN-1:0] hist;
      logic                filt;

      always_ff @(posedge clk) begin
        if (rst) begin
          hist <= '1;
          filt <= 1'b1;
        end else begin
          hist <= {hist[FILT_LEN-2:0], s2};
          if (&hist)
            filt <= 1'b1;
          else if (~|hist)
            filt <= 1'b0;
        end
      end

      assign level = filt;
    end else begin : g_plain
      assign level = s2;
    end
  endgenerate

endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 abort,
  input  logic                 fall,
  input  logic                 din,
  output logic                 busy,
  output logic                 valid,
  output logic                 err,
  output logic [DATA_BITS-1:0] data_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic [FRAME_BITS-1:0] frame_w;
  logic                  good_w;

  // frame_w[0] is the start bit, [8:1] data, [9] parity, [10] stop
  assign frame_w = {din, shreg};
  assign good_w  = ~frame_w[0] & frame_w[FRAME_BITS-1] & (^frame_w[DATA_BITS+1:1]);
  assign busy    = (bit_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
      valid   <= 1'b0;
      err     <= 1'b0;
      data_o  <= '0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      if (abort) begin
        bit_cnt <= '0;
      end else if (enable && fall) begin
        shreg <= {din, shreg[FRAME_BITS-2:1]};
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          bit_cnt <= '0;
          if (good_w) begin
            valid  <= 1'b1;
            data_o <= frame_w[DATA_BITS:1];
          end else begin
            err <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame
  import ps2_host_pkg::*;
#(
  parameter int INHIBIT_CYC = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 abort,
  input  logic                 fall,
  input  logic                 din,
  output logic                 busy,
  output logic                 waiting,
  output logic                 clk_pull_n,
  output logic                 data_pull_n,
  output logic                 done,
  output logic                 ack_ok
);

  localparam int INH_W  = $clog2(INHIBIT_CYC + 1);
  localparam int BIT_W  = $clog2(FRAME_BITS + 1);
  localparam int SHIFT_N = FRAME_BITS - 1;   // data + parity + stop

  tx_state_t          state;
  logic [INH_W-1:0]   inh_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [SHIFT_N-1:0] payload;

  assign busy    = (state != TX_IDLE);
  assign waiting = (state == TX_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TX_IDLE;
      inh_cnt     <= '0;
      bit_cnt     <= '0;
      payload     <= '1;
      clk_pull_n  <= 1'b1;
      data_pull_n <= 1'b1;
      done        <= 1'b0;
      ack_ok      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        state       <= TX_IDLE;
        clk_pull_n  <= 1'b1;
        data_pull_n <= 1'b1;
      end else begin
        unique case (state)
          TX_IDLE: begin
            if (go) begin
              payload    <= {1'b1, odd_parity(byte_i), byte_i};
              inh_cnt    <= '0;
              clk_pull_n <= 1'b0;
              state      <= TX_INHIBIT;
            end
          end
          TX_INHIBIT: begin
            inh_cnt <= inh_cnt + 1'b1;
            if (inh_cnt == INH_W'(INHIBIT_CYC - 1)) begin
              data_pull_n <= 1'b0;
              state       <= TX_START;
            end
          end
          TX_START: begin
            clk_pull_n <= 1'b1;
            bit_cnt    <= '0;
            state      <= TX_SHIFT;
          end
          TX_SHIFT: begin
            if (fall) begin
              if (bit_cnt == BIT_W'(SHIFT_N)) begin
                done        <= 1'b1;
                ack_ok      <= ~din;
                data_pull_n <= 1'b1;
                state       <= TX_IDLE;
              end else begin
                data_pull_n <= payload[bit_cnt[$clog2(SHIFT_N)-1:0]];
                bit_cnt     <= bit_cnt + 1'b1;
              end
            end
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ps2_host_ctrl.sv
module ps2_host_ctrl
  import ps2_host_pkg::*;
#(
  parameter int FILT_LEN    = 8,
  parameter int INHIBIT_CYC = 5000,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kb_clk_in,
  input  logic       kb_data_in,
  output logic       kb_clk_pull_n,
  output logic       kb_data_pull_n,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_err,
  output logic       tx_ready,
  input  logic       tx_req,
  input  logic [7:0] tx_byte,
  output logic       tx_done,
  output logic       tx_ack_ok
);

  localparam int WD_W = $clog2(TIMEOUT_CYC + 1);

  logic clk_lvl, data_lvl, clk_lvl_d, fall;
  logic rx_busy, tx_busy, tx_wait, tx_go, abort;
  logic [WD_W-1:0] wd_cnt;

  ps2_sync_filter #(.FILT_LEN(FILT_LEN)) u_clk_sync (
    .clk(clk), .rst(rst), .pin(kb_clk_in), .level(clk_lvl)
  );

  ps2_sync_filter #(.FILT_LEN(1)) u_data_sync (
    .clk(clk), .rst(rst), .pin(kb_data_in), .level(data_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_lvl_d <= 1'b1;
      fall      <= 1'b0;
    end else begin
      clk_lvl_d <= clk_lvl;
      fall      <= clk_lvl_d & ~clk_lvl;
    end
  end

  assign tx_ready = ~tx_busy & ~rx_busy;
  assign tx_go    = tx_req & tx_ready;

  // Watchdog: runs only while a frame waits for keyboard edges
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cnt <= '0;
      abort  <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (fall || !(rx_busy || tx_wait) || abort) begin
        wd_cnt <= '0;
      end else if (wd_cnt == WD_W'(TIMEOUT_CYC - 1)) begin
        wd_cnt <= '0;
        abort  <= 1'b1;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  ps2_rx_frame u_rx (
    .clk(clk), .rst(rst),
    .enable(~tx_busy & ~tx_go),
    .abort(abort), .fall(fall), .din(data_lvl),
    .busy(rx_busy), .valid(rx_valid), .err(rx_err), .data_o(rx_data)
  );

  ps2_tx_frame #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
    .clk(clk), .rst(rst),
    .go(tx_go), .byte_i(tx_byte),
    .abort(abort), .fall(fall), .din(data_lvl),
    .busy(tx_busy), .waiting(tx_wait),
    .clk_pull_n(kb_clk_pull_n), .data_pull_n(kb_data_pull_n),
    .done(tx_done), .ack_ok(tx_ack_ok)
  );

endmodule

// File: rtl/ps2_host_ctrl_chk.sv
module ps2_host_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic kb_clk_pull_n,
  input logic kb_data_pull_n,
  input logic rx_valid,
  input logic rx_err,
  input logic tx_ready,
  input logic tx_req,
  input logic tx_done
);

  // R2 and R3: a frame is either good or dropped, never both
  a_r2_one_verdict: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_err));

  // R2: the valid strobe lasts one cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6: the clock is handed back only with the start bit already low
  a_r6_start_before_release: assert property (@(posedge clk) disable iff (rst)
    $rose(kb_clk_pull_n) |-> !kb_data_pull_n);

  // R8: completion is a single pulse and leaves the block ready
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> tx_ready);

  // R9: whenever idle, both wires are released
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (kb_clk_pull_n && kb_data_pull_n));

  // R10: an accepted request starts the inhibit at once
  a_r10_accept: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_ready) |=> (!tx_ready && !kb_clk_pull_n));

endmodule

bind ps2_host_ctrl ps2_host_ctrl_chk u_chk (
  .clk(clk), .rst(rst),
  .kb_clk_pull_n(kb_clk_pull_n), .kb_data_pull_n(kb_data_pull_n),
  .rx_valid(rx_valid), .rx_err(rx_err),
  .tx_ready(tx_ready), .tx_req(tx_req), .tx_done(tx_done)
);

// File: tb/ps2_host_ctrl_bench.sv
module ps2_host_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 4;
  localparam int INHIBIT    = 200;
  localparam int TIMEOUT    = 1000;
  localparam int HALF       = 40;
  localparam int DUE        = FILT + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic kb_clk_pull_n, kb_data_pull_n;
  logic [7:0] rx_data;
  logic rx_valid, rx_err, tx_ready, tx_done, tx_ack_ok;
  logic tx_req = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  wire bus_clk = dev_clk & kb_clk_pull_n;
  wire bus_dat = dev_dat & kb_data_pull_n;

  int checks = 0, fails = 0;
  int done_seen = 0;
  logic last_ack = 1'b0;
  logic [8:0] exp_q[$];   // {err, byte}

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_ctrl #(.FILT_LEN(FILT), .INHIBIT_CYC(INHIBIT), .TIMEOUT_CYC(TIMEOUT)) u_ps2_host_ctrl (
    .clk(clk), .rst(rst),
    .kb_clk_in(bus_clk), .kb_data_in(bus_dat),
    .kb_clk_pull_n(kb_clk_pull_n), .kb_data_pull_n(kb_data_pull_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err),
    .tx_ready(tx_ready), .tx_req(tx_req), .tx_byte(tx_byte),
    .tx_done(tx_done), .tx_ack_ok(tx_ack_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops expected receive results as strobes appear
  always @(negedge clk) begin
    if (!rst && (rx_valid || rx_err)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected receive strobe", {rx_err, rx_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(rx_err == e[8], "R3/R4 verdict", rx_err, e[8]);
        if (!e[8]) check(rx_valid && rx_data == e[7:0], "R2 byte", rx_data, e[7:0]);
      end
    end
    if (!rst && tx_done) begin
      done_seen++;
      last_ack = tx_ack_ok;
    end
  end

  task automatic dev_bit(input logic b);
    dev_dat = b;
    wait_cyc(HALF/2);
    dev_clk = 1'b0;
    wait_cyc(HALF);
    dev_clk = 1'b1;
    wait_cyc(HALF/2);
  endtask

  // mode 0 good, 1 bad parity, 2 bad start, 3 bad stop; req_at pokes tx_req
  task automatic send_frame(input logic [7:0] d, input int mode, input int req_at);
    logic [10:0] f;
    f = {(mode == 3) ? 1'b0 : 1'b1, (~^d) ^ (mode == 1), d, (mode == 2) ? 1'b1 : 1'b0};
    exp_q.push_back({(mode != 0), d});
    for (int i = 0; i < 11; i++) begin
      if (i == req_at) begin
        check(tx_ready == 1'b0, "R10 ready low mid-frame", tx_ready, 0);
        tx_req = 1'b1; tx_byte = 8'hED;
        @(negedge clk);
        tx_req = 1'b0;
        wait_cyc(3);
        check(kb_clk_pull_n == 1'b1, "R10 request ignored mid-frame", kb_clk_pull_n, 1);
      end
      dev_bit(f[i]);
    end
    dev_dat = 1'b1;
    wait_cyc(DUE);
    check(exp_q.size() == 0, "R2 result due", exp_q.size(), 0);
  endtask

  task automatic host_send(input logic [7:0] d, input logic ack);
    logic [9:0] bits;
    int low;
    int done0;
    bits  = {1'b1, ~^d, d};
    done0 = done_seen;
    @(negedge clk);
    check(tx_ready == 1'b1, "R10 ready before send", tx_ready, 1);
    tx_req = 1'b1; tx_byte = d;
    @(negedge clk);
    tx_req = 1'b0;
    low = 0;
    while (kb_clk_pull_n == 1'b0) begin
      low++;
      @(negedge clk);
    end
    check(low >= INHIBIT, "R6 inhibit length", low, INHIBIT);
    check(kb_data_pull_n == 1'b0, "R6 start bit at clock release", kb_data_pull_n, 0);
    for (int k = 1; k <= 11; k++) begin
      if (k == 11) dev_dat = ack ? 1'b0 : 1'b1;
      wait_cyc(HALF/2);
      dev_clk = 1'b0;
      wait_cyc(HALF);
      dev_clk = 1'b1;
      if (k <= 10) check(bus_dat == bits[k-1], "R7 transmit bit", bus_dat, bits[k-1]);
      wait_cyc(HALF/2);
    end
    wait_cyc(DUE);
    dev_dat = 1'b1;
    check(done_seen == done0 + 1, "R8 done pulse", done_seen - done0, 1);
    check(last_ack == ack, "R8 acknowledge", last_ack, ack);
    check(tx_ready == 1'b1 && kb_data_pull_n && kb_clk_pull_n, "R8 ready after send", tx_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(kb_clk_pull_n && kb_data_pull_n, "R1 wires released", {kb_clk_pull_n, kb_data_pull_n}, 3);
    check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    check(!rx_valid && !rx_err && !tx_done, "R1 strobes low", {rx_valid, rx_err, tx_done}, 0);
    wait_cyc(20);

    send_frame(8'h38, 0, -1);   // R2 R3: parity 0 example
    send_frame(8'hA5, 0, -1);   // R2
    send_frame(8'h00, 0, -1);   // R2 R3: all zero, parity 1
    send_frame(8'h38, 1, -1);   // R3 wrong parity
    send_frame(8'h5A, 2, -1);   // R4 bad start
    send_frame(8'h5A, 3, -1);   // R4 bad stop

    // R5: short glitch then a clean frame
    dev_clk = 1'b0; wait_cyc(2); dev_clk = 1'b1; wait_cyc(20);
    send_frame(8'hC3, 0, -1);

    // R10: request during a frame is ignored
    send_frame(8'h1E, 0, 4);

    // R6 R7 R8: sends with and without acknowledge
    host_send(8'hED, 1'b1);
    host_send(8'h07, 1'b0);

    // R9: receive timeout mid-frame
    for (int i = 0; i < 5; i++) dev_bit(1'b0);
    dev_dat = 1'b1;
    check(tx_ready == 1'b0, "R9 frame in progress", tx_ready, 0);
    wait_cyc(TIMEOUT + 20);
    check(tx_ready == 1'b1, "R9 receive timeout to idle", tx_ready, 1);
    send_frame(8'h81, 0, -1);

    // R9: transmit timeout, keyboard never clocks
    begin
      int d0;
      d0 = done_seen;
      @(negedge clk);
      tx_req = 1'b1; tx_byte = 8'hF4;
      @(negedge clk);
      tx_req = 1'b0;
      wait_cyc(INHIBIT + TIMEOUT + 50);
      check(kb_clk_pull_n && kb_data_pull_n, "R9 wires released", {kb_clk_pull_n, kb_data_pull_n}, 3);
      check(tx_ready == 1'b1, "R9 transmit timeout to idle", tx_ready, 1);
      check(done_seen == d0, "R9 no done on timeout", done_seen - d0, 0);
    end
    send_frame(8'hFA, 0, -1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule